// File: doc/BRIEF.md
# Integer ALU with Compare-Set Operations

This block is the integer execute unit of a simple RISC pipeline. Each cycle it takes two 32-bit register operands, or one register operand and a 16-bit constant. It also takes a 4-bit operation code and a mode bit that selects signed or unsigned treatment. It returns a 32-bit result and a signed-overflow flag. The operations are add, subtract, three bitwise functions, four shifts, six compare-and-set tests that yield 0 or 1, and a load of the constant into the upper half.

The arithmetic is purely combinational. It is followed by one output register, so the result for the operands presented before a rising clock edge appears on the outputs just after that edge. Instruction decoding, register-file access and any trap taken on overflow belong to the surrounding pipeline.

Top module: `int_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `res` and `ovf` become 0. Otherwise each edge loads the result of the inputs sampled at that edge, giving a latency of exactly one clock.
- R2: Add (code 0) and subtract (code 1) return `a + b` and `a - b` modulo 2^32. The 32-bit result bits are the same in signed and unsigned mode.
- R3: `ovf` is 1 only for add or subtract in signed mode (`is_unsigned`=0) whose two's complement true result lies outside [-2^31, 2^31-1]. It is 0 for unsigned mode and for every other code.
- R4: AND (code 2), OR (code 3) and XOR (code 4) return the bitwise function of the operands, and `is_unsigned` has no effect on them.
- R5: Shift codes are 5 = arithmetic left, 6 = logical left, 7 = arithmetic right and 8 = logical right. The amount is the low 5 bits of the second operand. Both left shifts give the same result. A logical right shift fills with zeros, and an arithmetic right shift fills with bit 31 of the first operand. `is_unsigned` has no effect.
- R6: Compare codes are 9 = equal, 10 = not equal, 11 = less or equal, 12 = less, 13 = greater and 14 = greater or equal. Each returns 1 when the test holds and 0 otherwise, with all upper bits zero. Ordering is two's complement when `is_unsigned`=0 and unsigned magnitude when `is_unsigned`=1.
- R7: With `use_imm`=1 the second operand is the 16-bit `imm` widened to 32 bits. For codes 0, 1 and 9–14 it is sign-extended in signed mode and zero-extended in unsigned mode. For codes 2–8 it is always zero-extended.
- R8: Code 15 returns `imm` shifted left by 16 with the low half zero, whatever the values of `opa`, `opb`, `is_unsigned` and `use_imm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (see requirements) |
| is_unsigned | input | 1 | 1 selects unsigned treatment |
| use_imm | input | 1 | 1 replaces the second operand by the widened constant |
| opa | input | 32 | First operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Constant operand |
| res | output | 32 | Registered result |
| ovf | output | 1 | Registered signed overflow flag |

## Verification
The widening of the constant and the signed-or-unsigned ordering decision happen in the same cycle. Together they decide a compare-with-constant. The bench provokes this with a less-than test against constant 0x8000 in both modes. In signed mode the constant becomes a negative value. In unsigned mode it becomes a large positive one, so the two modes must give opposite answers for a small positive first operand. A second case applies a signed add of 0x7FFFFFFF and 1, which must raise the overflow flag and wrap the result in the same cycle; the unsigned form must leave the flag low. The expected value of each case is computed by a bench model.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,  OP_SUB = 4'd1,
        OP_AND = 4'd2,  OP_OR  = 4'd3,  OP_XOR = 4'd4,
        OP_SLA = 4'd5,  OP_SLL = 4'd6,  OP_SRA = 4'd7,  OP_SRL = 4'd8,
        OP_SEQ = 4'd9,  OP_SNE = 4'd10, OP_SLE = 4'd11,
        OP_SLT = 4'd12, OP_SGT = 4'd13, OP_SGE = 4'd14,
        OP_LHI = 4'd15
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_CMP, CLS_LHI
    } op_class_e;

    typedef struct packed {
        logic left;   // shift toward msb
        logic arith;  // replicate sign on right shift
    } shift_ctl_t;

    function automatic op_class_e op_class(alu_op_e op);
        case (op)
            OP_ADD, OP_SUB:                 return CLS_ARITH;
            OP_AND, OP_OR, OP_XOR:          return CLS_LOGIC;
            OP_SLA, OP_SLL, OP_SRA, OP_SRL: return CLS_SHIFT;
            OP_LHI:                         return CLS_LHI;
            default:                        return CLS_CMP;
        endcase
    endfunction

    // constant widening honours mode only where the operation has signed forms
    function automatic logic wants_sign_ext(alu_op_e op, logic uns);
        op_class_e c;
        c = op_class(op);
        return ((c == CLS_ARITH) || (c == CLS_CMP)) && !uns;
    endfunction

    function automatic shift_ctl_t shift_ctl(alu_op_e op);
        shift_ctl_t s;
        s.left  = (op == OP_SLA) || (op == OP_SLL);
        s.arith = (op == OP_SRA);
        return s;
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
`timescale 1ns/1ps
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  alu_op_e           op,
    input  logic              uns,
    input  logic              use_imm,
    input  logic [WIDTH-1:0]  reg_b,
    input  logic [IMM_W-1:0]  imm,
    output logic [WIDTH-1:0]  b_eff
);
    localparam int PAD = WIDTH - IMM_W;

    logic             sext;
    logic [WIDTH-1:0] imm_wide;

    always_comb begin
        sext     = wants_sign_ext(op, uns);
        imm_wide = {{PAD{sext & imm[IMM_W-1]}}, imm};
        b_eff    = use_imm ? imm_wide : reg_b;
    end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    input  logic             uns,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_in;
    logic             same_sign;

    always_comb begin
        b_in      = sub ? ~b : b;
        sum       = a + b_in + {{(WIDTH-1){1'b0}}, sub};
        same_sign = (a[MSB] == b_in[MSB]);
        ovf       = !uns && same_sign && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/alu_shifter.sv
`timescale 1ns/1ps
module alu_shifter
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SH_W-1:0]  amt,
    input  shift_ctl_t       ctl,
    output logic [WIDTH-1:0] y
);
    function automatic logic [WIDTH-1:0] bit_rev(logic [WIDTH-1:0] v);
        logic [WIDTH-1:0] r;
        for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
        return r;
    endfunction

    logic             fill;
    logic [WIDTH-1:0] stg [SH_W+1];

    assign fill   = ctl.arith & !ctl.left & a[WIDTH-1];
    assign stg[0] = ctl.left ? bit_rev(a) : a;

    for (genvar i = 0; i < SH_W; i++) begin : g_stage
        localparam int D = 1 << i;
        assign stg[i+1] = amt[i] ? {{D{fill}}, stg[i][WIDTH-1:D]} : stg[i];
    end

    assign y = ctl.left ? bit_rev(stg[SH_W]) : stg[SH_W];
endmodule

// File: rtl/alu_compare.sv
`timescale 1ns/1ps
module alu_compare
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic             uns,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             hit
);
    logic lt, eq;

    always_comb begin
        eq = (a == b);
        lt = uns ? (a < b) : ($signed(a) < $signed(b));
        case (op)
            OP_SEQ:  hit = eq;
            OP_SNE:  hit = !eq;
            OP_SLE:  hit = lt | eq;
            OP_SLT:  hit = lt;
            OP_SGT:  hit = !(lt | eq);
            default: hit = !lt;
        endcase
    end
endmodule

// File: rtl/int_alu.sv
`timescale 1ns/1ps
module int_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_sel,
    input  logic              is_unsigned,
    input  logic              use_imm,
    input  logic [WIDTH-1:0]  opa,
    input  logic [WIDTH-1:0]  opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [WIDTH-1:0]  res,
    output logic              ovf
);
    localparam int SH_W = $clog2(WIDTH);

    alu_op_e          op;
    op_class_e        cls;
    logic [WIDTH-1:0] b_eff, sum, sh_y, logic_y, nxt_res;
    logic             add_ovf, cmp_hit, nxt_ovf;

    assign op  = alu_op_e'(op_sel);
    assign cls = op_class(op);

    alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
        .op(op), .uns(is_unsigned), .use_imm(use_imm),
        .reg_b(opb), .imm(imm), .b_eff(b_eff)
    );

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a(opa), .b(b_eff), .sub(op == OP_SUB), .uns(is_unsigned),
        .sum(sum), .ovf(add_ovf)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .a(opa), .amt(b_eff[SH_W-1:0]), .ctl(shift_ctl(op)), .y(sh_y)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .op(op), .uns(is_unsigned), .a(opa), .b(b_eff), .hit(cmp_hit)
    );

    always_comb begin
        case (op)
            OP_AND:  logic_y = opa & b_eff;
            OP_OR:   logic_y = opa | b_eff;
            default: logic_y = opa ^ b_eff;
        endcase
    end

    always_comb begin
        nxt_ovf = 1'b0;
        case (cls)
            CLS_ARITH: begin
                nxt_res = sum;
                nxt_ovf = add_ovf;
            end
            CLS_LOGIC: nxt_res = logic_y;
            CLS_SHIFT: nxt_res = sh_y;
            CLS_CMP:   nxt_res = {{(WIDTH-1){1'b0}}, cmp_hit};
            default:   nxt_res = {{(WIDTH-IMM_W){1'b0}}, imm} << IMM_W;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
            ovf <= 1'b0;
        end else begin
            res <= nxt_res;
            ovf <= nxt_ovf;
        end
    end
endmodule

// File: rtl/int_alu_checker.sv
`timescale 1ns/1ps
module int_alu_checker #(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_sel,
    input logic              is_unsigned,
    input logic              use_imm,
    input logic [WIDTH-1:0]  opa,
    input logic [WIDTH-1:0]  opb,
    input logic [IMM_W-1:0]  imm,
    input logic [WIDTH-1:0]  res,
    input logic              ovf
);
    logic primed;
    always_ff @(posedge clk) primed <= !rst;

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (res == '0 && !ovf));

    assert_add_sum_R2: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_sel) == 4'd0 && !$past(use_imm)) |-> (res == $past(opa) + $past(opb)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst || !primed)
        ovf |-> ($past(op_sel) <= 4'd1 && !$past(is_unsigned)));

    assert_srl_zero_fill_R5: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_sel) == 4'd8 && !$past(use_imm) && $past(opb[4:0]) != 5'd0) |-> !res[WIDTH-1]);

    assert_cmp_boolean_R6: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_sel) >= 4'd9 && $past(op_sel) <= 4'd14) |-> (res[WIDTH-1:1] == '0));

    assert_lhi_shape_R8: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(op_sel) == 4'd15) |->
            (res[IMM_W-1:0] == '0 && res[WIDTH-1:IMM_W] == $past(imm)));
endmodule

bind int_alu int_alu_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
    .clk(clk), .rst(rst), .op_sel(op_sel), .is_unsigned(is_unsigned),
    .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm), .res(res), .ovf(ovf)
);

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic        is_unsigned = 1'b0;
    logic        use_imm = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic [15:0] imm = '0;
    logic [31:0] res;
    logic        ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    int_alu dut (
        .clk(clk), .rst(rst), .op_sel(op_sel), .is_unsigned(is_unsigned),
        .use_imm(use_imm), .opa(opa), .opb(opb), .imm(imm), .res(res), .ovf(ovf)
    );

    function automatic logic [31:0] model_b(int op, bit u, bit ui, logic [31:0] b, logic [15:0] k);
        bit sx;
        if (!ui) return b;
        sx = (op <= 1 || (op >= 9 && op <= 14)) && !u;
        return sx ? {{16{k[15]}}, k} : {16'h0, k};
    endfunction

    function automatic logic [31:0] model_res(int op, bit u, bit ui, logic [31:0] a, logic [31:0] b, logic [15:0] k);
        logic [31:0] bb;
        bit lt, eq;
        bb = model_b(op, u, ui, b, k);
        eq = (a == bb);
        lt = u ? (a < bb) : ($signed(a) < $signed(bb));
        case (op)
            0:  return a + bb;
            1:  return a - bb;
            2:  return a & bb;
            3:  return a | bb;
            4:  return a ^ bb;
            5, 6: return a << bb[4:0];
            7:  return $signed(a) >>> bb[4:0];
            8:  return a >> bb[4:0];
            9:  return {31'h0, eq};
            10: return {31'h0, !eq};
            11: return {31'h0, lt || eq};
            12: return {31'h0, lt};
            13: return {31'h0, !(lt || eq)};
            14: return {31'h0, !lt};
            default: return {k, 16'h0};
        endcase
    endfunction

    function automatic bit model_ovf(int op, bit u, bit ui, logic [31:0] a, logic [31:0] b, logic [15:0] k);
        longint sa, sb, r;
        if (op > 1 || u) return 1'b0;
        sa = longint'($signed(a));
        sb = longint'($signed(model_b(op, u, ui, b, k)));
        r  = (op == 0) ? sa + sb : sa - sb;
        return (r > 64'sd2147483647) || (r < -64'sd2147483648);
    endfunction

    function automatic string req_tag(int op, bit ui);
        if (ui && op != 15) return "R7";
        if (op <= 1)  return "R2";
        if (op <= 4)  return "R4";
        if (op <= 8)  return "R5";
        if (op <= 14) return "R6";
        return "R8";
    endfunction

    task automatic check32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run(int op, bit u, bit ui, logic [31:0] a, logic [31:0] b, logic [15:0] k);
        @(negedge clk);
        op_sel = op[3:0]; is_unsigned = u; use_imm = ui; opa = a; opb = b; imm = k;
        @(posedge clk);
        #1;
        check32(req_tag(op, ui), res, model_res(op, u, ui, a, b, k));
        check32("R3", {31'h0, ovf}, {31'h0, model_ovf(op, u, ui, a, b, k)});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check32("R1", res, 32'h0);
        check32("R1", {31'h0, ovf}, 32'h0);
        @(negedge clk);
        op_sel = 4'd0; opa = 32'h7FFF_FFFF; opb = 32'h1;
        rst = 1'b0;
        @(posedge clk); #1;
        // R1: one-clock latency, the first edge out of reset loads the sum
        check32("R1", res, 32'h8000_0000);
        check32("R3", {31'h0, ovf}, 32'h1);

        // R2 R3 wrap and overflow
        run(0, 0, 0, 32'h7FFF_FFFF, 32'h1, 16'h0);
        run(0, 1, 0, 32'h7FFF_FFFF, 32'h1, 16'h0);
        run(1, 0, 0, 32'h8000_0000, 32'h1, 16'h0);
        run(1, 1, 0, 32'h0, 32'h1, 16'h0);
        run(0, 1, 0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        // R4 mode has no effect on the bitwise functions
        run(2, 0, 0, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0);
        run(2, 1, 0, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0);
        run(3, 1, 0, 32'h0000_00F0, 32'h8000_000F, 16'h0);
        run(4, 1, 0, 32'hAAAA_5555, 32'hFFFF_0000, 16'h0);
        // R5 shifts: amount from low five bits, sign fill, left variants equal
        run(5, 0, 0, 32'h8000_0003, 32'd33, 16'h0);
        run(6, 1, 0, 32'h8000_0003, 32'd33, 16'h0);
        run(7, 1, 0, 32'h8000_0000, 32'd31, 16'h0);
        run(8, 0, 0, 32'h8000_0000, 32'd31, 16'h0);
        run(7, 0, 0, 32'h4000_0000, 32'd4, 16'h0);
        // R6 signed versus unsigned ordering
        run(12, 0, 0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        run(12, 1, 0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        run(11, 0, 0, 32'h5, 32'h5, 16'h0);
        run(13, 1, 0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0);
        run(9, 0, 0, 32'h1234, 32'h1234, 16'h0);
        run(10, 0, 0, 32'h1234, 32'h1234, 16'h0);
        // R7 constant widening
        run(0, 0, 1, 32'h10, 32'h0, 16'hFFFF);
        run(0, 1, 1, 32'h10, 32'h0, 16'hFFFF);
        run(12, 0, 1, 32'h5, 32'h0, 16'h8000);
        run(12, 1, 1, 32'h5, 32'h0, 16'h8000);
        run(2, 0, 1, 32'hFFFF_FFFF, 32'h0, 16'h8000);
        run(3, 0, 1, 32'h0, 32'h0, 16'hFFFF);
        // R8 load upper constant ignores the other inputs
        run(15, 0, 0, 32'hDEAD_BEEF, 32'h1234_5678, 16'hABCD);
        run(15, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h8001);

        for (int i = 0; i < 3000; i++) begin
            int op;
            logic [31:0] a, b;
            op = int'($urandom_range(0, 15));
            a = $urandom();
            b = $urandom();
            if (i % 7 == 0) b = a;
            if (i % 11 == 0) a = {a[31], 31'h7FFF_FFFF};
            run(op, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, b, 16'($urandom()));
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule